// File: doc/BRIEF.md
# SIMD Vector Multiply-Accumulate Unit

This block updates a 128-bit destination vector from its old contents and two 128-bit source vectors. Every lane multiplies a pair of source elements and adds the product to, or subtracts it from, the matching accumulator lane. All arithmetic wraps to the lane width, and no overflow indication is produced.

The same-width forms work on lanes of 8, 16, 32 or 64 bits. The widening forms read narrow elements of half the result width. They take only the even-numbered or only the odd-numbered narrow elements from both sources and extend them to the result width. Extension can be signed on both sides, unsigned on both sides, or mixed: zero-extend the first source and sign-extend the second. A caller puts the operands and a 6-bit opcode on the inputs and raises the input strobe for one cycle. The new destination vector appears one cycle later, together with an output strobe.

Top module: `macVecUnit`

## Requirements
- R1: While reset is asserted and after it is released, `validOut` is 0 and `result` is all zeros until the first accepted operation.
- R2: The opcode has three fields: bits [5:4] give the kind (0 multiply-add, 1 multiply-subtract, 2 widening on even elements, 3 widening on odd elements), bits [3:2] give the result lane width (0: 8, 1: 16, 2: 32, 3: 64 bits), and bits [1:0] give the sign mode (0 signed, 1 unsigned, 2 mixed, 3 reserved). An operation is accepted on a clock edge where `validIn` is 1. At the next edge `validOut` is 1 and `result` holds its value. Between accepted operations `result` keeps its value and `validOut` is 0.
- R3: Multiply-add sets each lane i of the result lane width to (acc[i] + j[i]*k[i]) mod 2^width, for all four widths and for sign modes 0 and 1.
- R4: Multiply-subtract sets each lane i to (acc[i] - j[i]*k[i]) mod 2^width, for all four widths and for sign modes 0 and 1.
- R5: Widening on even elements, with result width W of 16, 32 or 64, reads narrow elements 2i (of W/2 bits) from both sources. It extends them to W bits, multiplies them and adds the product, wrapped to W bits, into result lane i.
- R6: Widening on odd elements does the same using narrow elements 2i+1 of both sources.
- R7: Sign mode 0 sign-extends both narrow elements, and sign mode 1 zero-extends both.
- R8: Sign mode 2, used with a widening kind, zero-extends the element from `srcJ` and sign-extends the element from `srcK`.
- R9: Illegal combinations return `accIn` unchanged as the result. The illegal combinations are sign mode 3, a same-width kind with sign mode 2, and a widening kind with width code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Starts an operation this cycle |
| opcode | input | 6 | Kind, width and sign-mode fields |
| accIn | input | 128 | Old destination vector (accumulator) |
| srcJ | input | 128 | First source vector |
| srcK | input | 128 | Second source vector |
| validOut | output | 1 | Result produced by the operation of the previous cycle |
| result | output | 128 | New destination vector |

## Verification
Each result is due exactly one rising edge after the edge that accepts `validIn`. The bench drives inputs on the falling edge and samples `validOut` and `result` on the next falling edge, half a cycle after that rising edge. One cycle later, with `validIn` low and the inputs changed, it samples again to confirm that the output is held. Expected vectors come from a lane-by-lane bench model that uses 64-bit masks and explicit extension.

// File: rtl/macPkg.sv
package macPkg;
  localparam int VLEN = 128;
  localparam int NUM_WIDTHS = 4;
  localparam int OPW = 6;

  typedef enum logic [1:0] {KIND_MADD, KIND_MSUB, KIND_WEVEN, KIND_WODD} kind_e;
  typedef enum logic [1:0] {SGN_SS, SGN_UU, SGN_US, SGN_RSV} sign_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                  load;
    logic                  legal;
    logic                  doSub;
    logic                  widen;
    logic                  oddSel;
    logic                  extJ;
    logic                  extK;
    logic [NUM_WIDTHS-1:0] widthOh;
  } strobe_t;
endpackage

// File: rtl/macCtrl.sv
module macCtrl
  import macPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           validIn,
  input  logic [OPW-1:0] opcode,
  output strobe_t        strb,
  output logic           validOut
);
  kind_e kind;
  sign_e sgn;
  logic [1:0] wSel;

  always_comb begin
    kind = kind_e'(opcode[5:4]);
    wSel = opcode[3:2];
    sgn  = sign_e'(opcode[1:0]);
    strb.load    = validIn;
    strb.widen   = (kind == KIND_WEVEN) || (kind == KIND_WODD);
    strb.oddSel  = (kind == KIND_WODD);
    strb.doSub   = (kind == KIND_MSUB);
    strb.extJ    = (sgn == SGN_SS);
    strb.extK    = (sgn == SGN_SS) || (sgn == SGN_US);
    strb.widthOh = NUM_WIDTHS'(1) << wSel;
    strb.legal   = 1'b1;
    if (sgn == SGN_RSV) strb.legal = 1'b0;
    if (!strb.widen && sgn == SGN_US) strb.legal = 1'b0;
    if (strb.widen && wSel == 2'd0) strb.legal = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end
endmodule

// File: rtl/macDatapath.sv
module macDatapath
  import macPkg::*;
#(
  parameter int VW = VLEN
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [VW-1:0] accIn,
  input  logic [VW-1:0] srcJ,
  input  logic [VW-1:0] srcK,
  output logic [VW-1:0] result
);
  logic [VW-1:0] laneRes [NUM_WIDTHS];
  logic [VW-1:0] nextRes;

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : gWidth
    localparam int W = 8 << g;
    localparam int NW = W / 2;
    localparam int LANES = VW / W;
    for (genvar l = 0; l < LANES; l++) begin : gLane
      logic [W-1:0] accL, opA, opB, prod;
      logic [NW-1:0] jN, kN;
      always_comb begin
        accL = accIn[l*W +: W];
        jN = strb.oddSel ? srcJ[(2*l+1)*NW +: NW] : srcJ[(2*l)*NW +: NW];
        kN = strb.oddSel ? srcK[(2*l+1)*NW +: NW] : srcK[(2*l)*NW +: NW];
        if (strb.widen) begin
          opA = {{NW{strb.extJ & jN[NW-1]}}, jN};
          opB = {{NW{strb.extK & kN[NW-1]}}, kN};
        end else begin
          opA = srcJ[l*W +: W];
          opB = srcK[l*W +: W];
        end
        prod = opA * opB;
      end
      assign laneRes[g][l*W +: W] = strb.doSub ? accL - prod : accL + prod;
    end
  end

  always_comb begin
    nextRes = accIn;
    if (strb.legal) begin
      for (int g = 0; g < NUM_WIDTHS; g++)
        if (strb.widthOh[g]) nextRes = laneRes[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          result <= '0;
    else if (strb.load) result <= nextRes;
  end

  // R2: output held while no operation is accepted
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(result));
  // R9: illegal combinations return the accumulator
  assert_passthru_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.legal) |=> result == $past(accIn));
  // R3: a zero first source gives a zero product, so the lanes keep the accumulator
  assert_zero_product_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && srcJ == '0) |=> result == $past(accIn));
endmodule

// File: rtl/macVecUnit.sv
module macVecUnit
  import macPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  input  logic [5:0]   opcode,
  input  logic [127:0] accIn,
  input  logic [127:0] srcJ,
  input  logic [127:0] srcK,
  output logic         validOut,
  output logic [127:0] result
);
  strobe_t strb;

  macCtrl uCtrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opcode(opcode),
    .strb(strb), .validOut(validOut)
  );

  macDatapath #(.VW(VLEN)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .accIn(accIn),
    .srcJ(srcJ), .srcK(srcK), .result(result)
  );

  // R2: an output strobe always follows an input strobe by one cycle
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> $past(validIn));
endmodule

// File: tb/tb_macVecUnit.sv
`timescale 1ns/1ps
module tb_macVecUnit;
  logic clk = 0, rstN = 0, validIn = 0;
  logic [5:0] opcode = '0;
  logic [127:0] accIn = '0, srcJ = '0, srcK = '0;
  logic validOut;
  logic [127:0] result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  macVecUnit dut (.clk(clk), .rstN(rstN), .validIn(validIn), .opcode(opcode),
    .accIn(accIn), .srcJ(srcJ), .srcK(srcK), .validOut(validOut), .result(result));

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] extend(logic [63:0] v, int n, bit sgn);
    logic [63:0] m = (n == 64) ? '1 : ((64'd1 << n) - 1);
    v &= m;
    if (sgn && v[n-1]) v |= ~m;
    return v;
  endfunction

  // bench reference model, built from R2..R9
  function automatic logic [127:0] refModel(logic [5:0] op, logic [127:0] a, logic [127:0] j, logic [127:0] k);
    int kind = op[5:4], ws = op[3:2], sm = op[1:0];
    int w = 8 << ws, n = w / 2;
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [127:0] o = '0;
    if (sm == 3 || (kind < 2 && sm == 2) || (kind >= 2 && ws == 0)) return a;
    for (int l = 0; l < 128 / w; l++) begin
      logic [63:0] acc, x, y, p, r;
      acc = 64'(a >> (l * w)) & m;
      if (kind < 2) begin
        x = 64'(j >> (l * w)) & m;
        y = 64'(k >> (l * w)) & m;
      end else begin
        int idx = 2 * l + ((kind == 3) ? 1 : 0);
        x = extend(64'(j >> (idx * n)), n, sm == 0);
        y = extend(64'(k >> (idx * n)), n, sm == 0 || sm == 2);
      end
      p = (x * y) & m;
      r = ((kind == 1) ? acc - p : acc + p) & m;
      o |= 128'(r) << (l * w);
    end
    return o;
  endfunction

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic runOp(string req, logic [5:0] op, logic [127:0] a, logic [127:0] j, logic [127:0] k);
    logic [127:0] exp = refModel(op, a, j, k);
    @(negedge clk);
    validIn = 1; opcode = op; accIn = a; srcJ = j; srcK = k;
    @(negedge clk);
    validIn = 0;
    chk({req, " validOut"}, 128'(validOut), 128'd1);
    chk(req, result, exp);
    accIn = rnd128(); srcJ = rnd128(); srcK = rnd128(); opcode = 6'($urandom());
    @(negedge clk);
    chk("R2 hold validOut", 128'(validOut), 128'd0);
    chk("R2 hold result", result, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset validOut", 128'(validOut), 128'd0);
    chk("R1 reset result", result, '0);
    rstN = 1;
    @(negedge clk);
    chk("R1 after reset result", result, '0);
    // R3 byte wrap: 0x80*0x02 overflows to 0
    runOp("R3 madd8", 6'b00_00_00, {16{8'h01}}, {16{8'h80}}, {16{8'h02}});
    runOp("R3 madd64", 6'b00_11_01, {64'd5, 64'hFFFF_FFFF_FFFF_FFFF}, {64'd3, 64'd2}, {64'd7, 64'd1});
    // R4 subtract wrap to all ones
    runOp("R4 msub64", 6'b01_11_00, '0, {2{64'd1}}, {2{64'd1}});
    runOp("R4 msub16", 6'b01_01_01, {8{16'h1234}}, {8{16'hFFFF}}, {8{16'h0002}});
    // R5 even signed: -1 * 2 = -2 in 16-bit lanes
    runOp("R5 even s8", 6'b10_01_00, '0, {8{8'h11, 8'hFF}}, {8{8'h33, 8'h02}});
    // R6 odd picks upper bytes only
    runOp("R6 odd s8", 6'b11_01_00, {8{16'h0100}}, {8{8'h11, 8'hFF}}, {8{8'h33, 8'h02}});
    // R7 unsigned: 0xFF*0xFF = 0xFE01
    runOp("R7 even u8", 6'b10_01_01, '0, {16{8'hFF}}, {16{8'hFF}});
    runOp("R7 odd s32", 6'b11_11_00, {2{64'd10}}, {4{32'h8000_0000}}, {4{32'hFFFF_FFFF}});
    // R8 mixed: 255 * -1 = 0xFF01
    runOp("R8 mixed8", 6'b10_01_10, '0, {16{8'hFF}}, {16{8'hFF}});
    runOp("R8 mixed32", 6'b11_11_10, '0, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFE}});
    // R9 illegal combinations
    runOp("R9 reserved sign", 6'b00_10_11, rnd128(), rnd128(), rnd128());
    runOp("R9 madd mixed", 6'b00_01_10, rnd128(), rnd128(), rnd128());
    runOp("R9 widen w8", 6'b10_00_00, rnd128(), rnd128(), rnd128());
    for (int i = 0; i < 400; i++)
      runOp("R3-R9 random", 6'($urandom()), rnd128(), rnd128(), rnd128());
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule